// File: doc/BRIEF.md
# Halfword Flip-Mask Correction Applier

This block sits behind a BCH decoder. It takes the decoder's status word and its list of error reports, and it repairs a data block that already sits in a byte-addressed RAM. A pulse on `start_i` captures the status word. If the status marks the block as uncorrectable, the pass ends at once and memory is left alone. If the status shows no error, the pass reports that nothing was done. In every other case the block reads the report entries one at a time, in ascending order. For each entry it XORs a 16-bit flip mask into the addressed halfword, one byte at a time, using a read-modify-write on each byte.

At the end of the pass the block gives a single-cycle `done_o` pulse together with a result code. When the pass succeeds, it also reports the decoder's total corrected-bit figure. An entry that points past the configured block length is skipped, and the skip is recorded in a flag that stays set until the next pass begins. The block does not compute syndromes and does not locate errors.

Top module: `ecc_fix_applier`

## Requirements
- R1: After reset, `done_o`, `range_err_o`, `rpt_rd_o`, `mem_rd_o` and `mem_wr_o` are low, `result_o` is 0 (none) and `fixed_bits_o` is 0.
- R2: When status bit 1 (uncorrectable) is set at start, the pass ends with `result_o` = 2 and `fixed_bits_o` = 0, and no RAM write is made.
- R3: When status bit 1 is clear and status bit 0 (error present) is clear, the pass ends with `result_o` = 0 and `fixed_bits_o` = 0, and no RAM write is made.
- R4: A report word carries a halfword index in bits 10:0 and a flip mask in bits 31:16. Mask bits 7:0 are XORed into data byte 2*index, and mask bits 15:8 are XORed into data byte 2*index+1.
- R5: The number of entries comes from status bits 30:24. Entry i is read from report word address i, and the entries are read in ascending order starting at address 0.
- R6: A successful pass ends with `result_o` = 1, and `fixed_bits_o` equals status bits 22:16, not the number of entries.
- R7: Each byte is updated by a RAM read followed, in the next cycle, by a write to the same address. A repeated index therefore accumulates both masks.
- R8: An entry whose index is not below `blk_hw_i` causes no RAM access. It sets `range_err_o`, which stays high until the next start.
- R9: `done_o` is high for exactly one cycle per pass, and `result_o` and `fixed_bits_o` hold their values after `done_o` until the next start.
- R10: When status bits 1 and 0 are both set, the uncorrectable outcome of R2 takes precedence over correction.
- R11: When status bit 0 is set and the entry count is zero, the pass ends with `result_o` = 1, `fixed_bits_o` equal to status bits 22:16, and no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a pass and captures `status_i` |
| status_i | input | 32 | Decoder status word, valid together with `start_i` |
| blk_hw_i | input | 12 | Block length in halfwords; an index must be below this value |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| result_o | output | 2 | Result code: 0 none, 1 corrected, 2 uncorrectable |
| fixed_bits_o | output | 7 | Corrected-bit total from the status word |
| range_err_o | output | 1 | Set when an entry was skipped for being out of range |
| rpt_rd_o | output | 1 | Read strobe for the report store |
| rpt_idx_o | output | 7 | Word address of the report being read |
| rpt_word_i | input | 32 | Report word, returned one cycle after the read strobe |
| mem_rd_o | output | 1 | Data RAM read strobe |
| mem_wr_o | output | 1 | Data RAM write strobe |
| mem_addr_o | output | 12 | Data RAM byte address |
| mem_wdata_o | output | 8 | Data RAM write byte |
| mem_rdata_i | input | 8 | Data RAM read byte, returned one cycle after the read strobe |

## Verification
The patterns are designed so that each one separates two readings of the requirements:
- **Uncorrectable with entries present, versus no error flag with entries present.** Both patterns carry entries, so a design that walks the list in the wrong case is caught by a changed memory or a nonzero write count.
- **Successful pass with a corrected-bit total that differs from the entry count.** This pattern shows which of the two values reaches `fixed_bits_o`.
- **Repeated index.** Only a true read-modify-write on the already-updated byte gives the XOR of both masks.
- **Indices at the range limit.** Placing entries at `blk_hw_i`-1, at `blk_hw_i` and at the top index separates the correct bound from an off-by-one.
- **Pass after a range error.** A clean pass that follows a skip shows that the flag clears at start.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

   // result codes presented with done
   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_OK    = 2'd1,
      RES_UNCOR = 2'd2
   } fix_res_e;

   // sequencer states
   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_RPT_REQ = 3'd1,
      S_RPT_CAP = 3'd2,
      S_RD_REQ  = 3'd3,
      S_WR      = 3'd4,
      S_FIN     = 3'd5
   } fix_st_e;

   // status word layout
   localparam int ST_ERR_BIT = 0;
   localparam int ST_UNC_BIT = 1;
   localparam int ST_TOT_LSB = 16;
   localparam int ST_CNT_LSB = 24;

   // report word layout
   localparam int RPT_IDX_LSB  = 0;
   localparam int RPT_MASK_LSB = 16;

endpackage

// File: rtl/ecc_status_decode.sv
module ecc_status_decode
   import ecc_fix_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 7
) (
   input  logic [WORD_W-1:0] status_i,
   output logic              err_o,
   output logic              uncor_o,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  total_o
);

   logic unused_status;

   assign err_o   = status_i[ST_ERR_BIT];
   assign uncor_o = status_i[ST_UNC_BIT];
   assign count_o = status_i[ST_CNT_LSB +: CNT_W];
   assign total_o = status_i[ST_TOT_LSB +: CNT_W];
   assign unused_status = ^status_i;

endmodule

// File: rtl/ecc_entry_unpack.sv
module ecc_entry_unpack
   import ecc_fix_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 11,
   parameter int MASK_W = 16,
   parameter int DATA_W = 8,
   parameter int LANES  = 2,
   parameter int LANE_W = 1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [IDX_W:0]    limit_i,
   input  logic [LANE_W-1:0] lane_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic [DATA_W-1:0] mask_byte_o,
   output logic              in_range_o
);

   logic [MASK_W-1:0] mask;
   logic [DATA_W-1:0] lane_bytes [LANES];
   logic              unused_word;

   assign idx_o       = word_i[RPT_IDX_LSB +: IDX_W];
   assign mask        = word_i[RPT_MASK_LSB +: MASK_W];
   assign in_range_o  = ({1'b0, idx_o} < limit_i);
   assign unused_word = ^word_i;

   // lane g covers mask bits g*DATA_W upward: lane 0 goes to the even byte
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_bytes[g] = mask[g*DATA_W +: DATA_W];
   end

   assign mask_byte_o = lane_bytes[lane_i];

endmodule

// File: rtl/ecc_fix_applier.sv
module ecc_fix_applier
   import ecc_fix_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 11,
   parameter int CNT_W  = 7,
   parameter int DATA_W = 8,
   parameter int MASK_W = 16,
   localparam int LANES  = MASK_W / DATA_W,
   localparam int LANE_W = $clog2(LANES),
   localparam int MEM_AW = IDX_W + LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] status_i,
   input  logic [IDX_W:0]    blk_hw_i,
   output logic              done_o,
   output logic [1:0]        result_o,
   output logic [CNT_W-1:0]  fixed_bits_o,
   output logic              range_err_o,
   output logic              rpt_rd_o,
   output logic [CNT_W-1:0]  rpt_idx_o,
   input  logic [WORD_W-1:0] rpt_word_i,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [MEM_AW-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i
);

   // elaboration-time parameter checks
   if (LANES < 2 || (1 << LANE_W) != LANES || LANES * DATA_W != MASK_W) begin : g_bad_lanes
      $error("MASK_W must be a power-of-two multiple (>=2) of DATA_W");
   end
   if (RPT_MASK_LSB + MASK_W > WORD_W || IDX_W > RPT_MASK_LSB) begin : g_bad_rpt
      $error("report fields do not fit the word");
   end
   if (ST_CNT_LSB + CNT_W > WORD_W || ST_TOT_LSB + CNT_W > ST_CNT_LSB) begin : g_bad_stat
      $error("status fields do not fit the word");
   end

   fix_st_e           st_q;
   logic [CNT_W-1:0]  cnt_q, ent_q, tot_q;
   logic [LANE_W-1:0] lane_q;
   logic [WORD_W-1:0] word_q;
   logic              uncor_q, rng_q;
   fix_res_e          res_q;
   logic [CNT_W-1:0]  fixed_q;

   // status decode
   logic             d_err, d_uncor;
   logic [CNT_W-1:0] d_cnt, d_tot;

   ecc_status_decode #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_stat (
      .status_i (status_i),
      .err_o    (d_err),
      .uncor_o  (d_uncor),
      .count_o  (d_cnt),
      .total_o  (d_tot)
   );

   // entry unpack: in the capture state look at the fresh word, else at the held one
   logic [WORD_W-1:0] cur_word;
   logic [IDX_W-1:0]  e_idx;
   logic [DATA_W-1:0] e_mask_byte;
   logic              e_in_range;

   assign cur_word = (st_q == S_RPT_CAP) ? rpt_word_i : word_q;

   ecc_entry_unpack #(
      .WORD_W (WORD_W), .IDX_W (IDX_W), .MASK_W (MASK_W),
      .DATA_W (DATA_W), .LANES (LANES), .LANE_W (LANE_W)
   ) u_unpack (
      .word_i      (cur_word),
      .limit_i     (blk_hw_i),
      .lane_i      (lane_q),
      .idx_o       (e_idx),
      .mask_byte_o (e_mask_byte),
      .in_range_o  (e_in_range)
   );

   logic last_ent;
   assign last_ent = (ent_q == cnt_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         cnt_q   <= '0;
         ent_q   <= '0;
         tot_q   <= '0;
         lane_q  <= '0;
         word_q  <= '0;
         uncor_q <= 1'b0;
         rng_q   <= 1'b0;
         res_q   <= RES_NONE;
         fixed_q <= '0;
      end else begin
         case (st_q)
            S_IDLE: begin
               if (start_i) begin
                  cnt_q   <= d_cnt;
                  tot_q   <= d_tot;
                  uncor_q <= d_uncor;
                  ent_q   <= '0;
                  lane_q  <= '0;
                  rng_q   <= 1'b0;
                  if (d_uncor) begin
                     res_q   <= RES_UNCOR;
                     fixed_q <= '0;
                     st_q    <= S_FIN;
                  end else if (!d_err) begin
                     res_q   <= RES_NONE;
                     fixed_q <= '0;
                     st_q    <= S_FIN;
                  end else begin
                     res_q   <= RES_OK;
                     fixed_q <= d_tot;
                     st_q    <= (d_cnt == '0) ? S_FIN : S_RPT_REQ;
                  end
               end
            end
            S_RPT_REQ: st_q <= S_RPT_CAP;
            S_RPT_CAP: begin
               word_q <= rpt_word_i;
               lane_q <= '0;
               if (e_in_range) begin
                  st_q <= S_RD_REQ;
               end else begin
                  rng_q <= 1'b1;
                  if (last_ent) st_q <= S_FIN;
                  else begin
                     ent_q <= ent_q + 1'b1;
                     st_q  <= S_RPT_REQ;
                  end
               end
            end
            S_RD_REQ: st_q <= S_WR;
            S_WR: begin
               if (lane_q == LANE_W'(LANES - 1)) begin
                  lane_q <= '0;
                  if (last_ent) st_q <= S_FIN;
                  else begin
                     ent_q <= ent_q + 1'b1;
                     st_q  <= S_RPT_REQ;
                  end
               end else begin
                  lane_q <= lane_q + 1'b1;
                  st_q   <= S_RD_REQ;
               end
            end
            S_FIN:   st_q <= S_IDLE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign done_o       = (st_q == S_FIN);
   assign result_o     = res_q;
   assign fixed_bits_o = fixed_q;
   assign range_err_o  = rng_q;
   assign rpt_rd_o     = (st_q == S_RPT_REQ);
   assign rpt_idx_o    = ent_q;
   assign mem_rd_o     = (st_q == S_RD_REQ);
   assign mem_wr_o     = (st_q == S_WR);
   assign mem_addr_o   = {e_idx, lane_q};
   assign mem_wdata_o  = mem_rdata_i ^ e_mask_byte;

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R2
   uncor_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> !uncor_q);

   // R7
   rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> ($past(mem_rd_o) && mem_addr_o == $past(mem_addr_o)));

   // R8
   range_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> ({1'b0, mem_addr_o[MEM_AW-1:LANE_W]} < blk_hw_i));

   // R7
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rpt_rd_o, mem_rd_o, mem_wr_o}));

   // R5
   rpt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_rd_o && $past(rpt_rd_o) == 1'b0 && rpt_idx_o != '0) |-> (rpt_idx_o == $past(rpt_idx_o) + 1'b1 || $past(rpt_idx_o) == rpt_idx_o - 1'b1));

endmodule

// File: tb/sim_ecc_fix_applier.sv
module sim_ecc_fix_applier;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_BYTES  = 4096;

   typedef struct packed {
      logic [1:0] res;
      logic [6:0] fixed;
      logic       rng;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] status_i = '0;
   logic [11:0] blk_hw_i = 12'd2048;
   logic        done_o, range_err_o, rpt_rd_o, mem_rd_o, mem_wr_o;
   logic [1:0]  result_o;
   logic [6:0]  fixed_bits_o, rpt_idx_o;
   logic [31:0] rpt_word_i = '0;
   logic [11:0] mem_addr_o;
   logic [7:0]  mem_wdata_o;
   logic [7:0]  mem_rdata_i = '0;

   ecc_fix_applier u0 (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .status_i (status_i),
      .blk_hw_i (blk_hw_i), .done_o (done_o), .result_o (result_o),
      .fixed_bits_o (fixed_bits_o), .range_err_o (range_err_o),
      .rpt_rd_o (rpt_rd_o), .rpt_idx_o (rpt_idx_o), .rpt_word_i (rpt_word_i),
      .mem_rd_o (mem_rd_o), .mem_wr_o (mem_wr_o), .mem_addr_o (mem_addr_o),
      .mem_wdata_o (mem_wdata_o), .mem_rdata_i (mem_rdata_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [7:0]  mem  [MEM_BYTES];
   logic [7:0]  gold [MEM_BYTES];
   logic [31:0] rpt  [128];
   int          wr_cnt, exp_rpt, done_cnt;
   bit          order_bad;
   int          tests, fails;
   bit          finished;
   exp_t        expq [$];

   // RAM and report-store models, one cycle read latency
   always @(posedge clk) begin
      if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
      if (mem_wr_o) begin
         mem[mem_addr_o] <= mem_wdata_o;
         wr_cnt <= wr_cnt + 1;
      end
      if (rpt_rd_o) begin
         rpt_word_i <= rpt[rpt_idx_o];
         if (int'(rpt_idx_o) != exp_rpt) order_bad <= 1'b1;
         exp_rpt <= exp_rpt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: compares each done against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         done_cnt <= done_cnt + 1;
         if (expq.size() == 0) check(1'b0, "R9", "unexpected done", 1, 0);
         else begin
            exp_t e;
            e = expq.pop_front();
            check(result_o == e.res, "R2/R3/R6 (R10 R11)", "result", result_o, e.res);
            check(fixed_bits_o == e.fixed, "R6", "fixed bits", fixed_bits_o, e.fixed);
            check(range_err_o == e.rng, "R8", "range flag", range_err_o, e.rng);
         end
      end
   end

   function automatic logic [31:0] mk_stat(bit unc, bit err, int cnt, int tot);
      return {1'b0, 7'(cnt), 1'b0, 7'(tot), 14'd0, unc, err};
   endfunction

   // driver: computes the expected outcome, pushes it, runs the pass
   task automatic run_op(input logic [31:0] st, input int blk, input string tag);
      exp_t e;
      int   cnt, wexp, prev;
      bit   rng;
      cnt = int'(st[30:24]);
      rng = 1'b0;
      wexp = 0;
      if (st[1]) begin
         e.res = 2'd2; e.fixed = 7'd0;
      end else if (!st[0]) begin
         e.res = 2'd0; e.fixed = 7'd0;
      end else begin
         e.res = 2'd1; e.fixed = st[22:16];
         for (int i = 0; i < cnt; i++) begin
            int idx;
            idx = int'(rpt[i][10:0]);
            if (idx < blk) begin
               gold[2*idx]   ^= rpt[i][23:16];
               gold[2*idx+1] ^= rpt[i][31:24];
               wexp += 2;
            end else rng = 1'b1;
         end
      end
      e.rng = rng;
      expq.push_back(e);
      @(negedge clk);
      wr_cnt = 0; exp_rpt = 0; order_bad = 1'b0;
      prev = done_cnt;
      status_i = st; blk_hw_i = 12'(blk); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (done_cnt == prev) @(negedge clk);
      repeat (3) @(negedge clk);
      check(result_o == e.res && fixed_bits_o == e.fixed, "R9", {tag, " held"}, result_o, e.res);
      check(wr_cnt == wexp, "R7", {tag, " write count"}, wr_cnt, wexp);
      check(!order_bad, "R5", {tag, " report order"}, int'(order_bad), 0);
      begin
         int bad;
         bad = 0;
         for (int a = 0; a < MEM_BYTES; a++) if (mem[a] !== gold[a]) bad++;
         check(bad == 0, "R4", {tag, " memory image"}, bad, 0);
      end
   endtask

   initial begin
      for (int a = 0; a < MEM_BYTES; a++) begin
         mem[a]  = 8'(a * 7 + 3);
         gold[a] = 8'(a * 7 + 3);
      end
      for (int i = 0; i < 128; i++) rpt[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!done_o && !range_err_o && !rpt_rd_o && !mem_rd_o && !mem_wr_o,
            "R1", "strobes in reset", 1, 0);
      check(result_o == 2'd0 && fixed_bits_o == 7'd0, "R1", "result in reset", result_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      rpt[0] = {16'hA55A, 5'd0, 11'd10};
      rpt[1] = {16'h0F01, 5'd0, 11'd3};
      rpt[2] = {16'h8000, 5'd0, 11'd40};
      // R2 / R10: uncorrectable with error flag and entries
      run_op(mk_stat(1, 1, 3, 5), 2048, "uncor");
      // R3: no error flag, entries present
      run_op(mk_stat(0, 0, 3, 4), 2048, "noerr");
      // R6: total differs from count
      run_op(mk_stat(0, 1, 3, 9), 2048, "ok3");
      // R8: out-of-range entry skipped
      rpt[0] = {16'h1234, 5'd0, 11'd150};
      rpt[1] = {16'h00FF, 5'd0, 11'd99};
      rpt[2] = {16'hFF00, 5'd0, 11'd100};
      rpt[3] = {16'h3C3C, 5'd0, 11'd5};
      run_op(mk_stat(0, 1, 4, 12), 100, "range");
      // R8: flag cleared by next start
      rpt[0] = {16'h0101, 5'd0, 11'd7};
      run_op(mk_stat(0, 1, 1, 1), 100, "clean");
      // R7: repeated index accumulates both masks
      rpt[0] = {16'h00F0, 5'd0, 11'd20};
      rpt[1] = {16'h0F0F, 5'd0, 11'd20};
      rpt[2] = {16'hC003, 5'd0, 11'd21};
      run_op(mk_stat(0, 1, 3, 2), 2048, "dup");
      // R11: error flag with zero entries
      run_op(mk_stat(0, 1, 0, 6), 2048, "zero");
      // R4: top halfword index
      rpt[0] = {16'hBEEF, 5'd0, 11'd2047};
      rpt[1] = {16'h0001, 5'd0, 11'd0};
      run_op(mk_stat(0, 1, 2, 127), 2048, "top");

      check(expq.size() == 0, "R9", "pending results", expq.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1'b1;
         check(1'b0, "R9", "watchdog", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule